// File: doc/BRIEF.md
# Multichannel serial audio transmitter

This block takes sets of eight parallel audio samples and sends them out on four serial data lanes, two channels per lane, framed by a word-select line and paced by an externally supplied serial bit clock. Word-select low carries the left channel of every lane and word-select high carries the right channel. The most significant bit of each sample goes first, one bit clock after the word-select change, in the usual two-channel serial audio layout.

The block is either the timing master, driving word select itself with a frame of twice the sample width, or the timing slave, following an external word select and aligning its framing to that line's transitions. A second setting picks which bit-clock edge launches data; in slave mode word select is sampled on the other edge. The bit clock is an ordinary input that the block samples on its own system clock, so that clock must run several times faster than the bit clock.

Sample sets arrive through a valid/ready handshake into a one-set holding register, and one set is taken at each frame start. If no set is waiting when a frame starts, the previous set is sent again and a sticky underrun flag rises.

Top module: `multichan_audio_tx`

## Requirements
- R1: Lane k (k = 0..3) carries channel 2k while word select is low and channel 2k+1 while it is high; channel c occupies bits [c*W +: W] of `s_data`, and each sample goes out MSB first.
- R2: In master mode a frame is 2*W bit clocks; `ws_out` goes high one bit clock before the right-channel MSB and low one bit clock before the left-channel MSB.
- R3: In master mode `ws_oe` is 1 and `ws_out` changes only on the launching bit-clock edge, the same edge on which the data lanes change.
- R4: During and after reset the block is a slave (`ws_oe` = 0), all lanes are 0, `s_ready` = 1 and `underrun` = 0.
- R5: With `cfg_launch_fall` = 0 the lanes change only on rising `sck` edges; with 1 only on falling edges.
- R6: In slave mode `ws_in` is sampled on the bit-clock edge opposite the launching edge; after a sampled change the next launching edge sends the MSB of the channel the new level selects.
- R7: In slave mode, after reset or any change of `cfg_master`, all lanes stay 0 until the first change of the sampled word select; a mode change in either direction restarts framing.
- R8: `s_ready` is 1 exactly while the holding register is empty; a set accepted with `s_valid` and `s_ready` is used from the next frame start, one set per frame.
- R9: When a frame starts with the holding register empty, the previous set is sent again and `underrun` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples `sck` and `ws_in` |
| rst_n | input | 1 | Synchronous reset, active low |
| sck | input | 1 | Serial bit clock, slower than `clk` |
| cfg_master | input | 1 | 1 = timing master, 0 = timing slave |
| cfg_launch_fall | input | 1 | 1 = data launches on falling `sck`, 0 = on rising |
| s_valid | input | 1 | Sample set offered |
| s_ready | output | 1 | Holding register empty |
| s_data | input | 8*W | Eight samples, channel c at bits [c*W +: W] |
| ws_in | input | 1 | External word select (slave mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| ws_oe | output | 1 | Output enable for word select, 1 in master mode |
| sd | output | 4 | Serial data lanes |
| underrun | output | 1 | Sticky: a frame started without a new set |

## Verification
The bench builds the block with an 8-bit sample width and the default four lanes, so a frame is only 16 bit clocks and each mode runs through several full frames, wraps and set loads. With that short frame the slave mode can be started at two different phases of the external word select, one whose first transition leads into a right channel and one into a left channel. It also has time for master mode with both launch edges, a mode change mid-stream, and a stretch without feeding that forces the repeat and sticky flag.

// File: rtl/sao_pkg.sv
// Shared definitions for the multichannel serial audio transmitter.
// Assumes: two channels per lane, left/right order fixed by word select.
package sao_pkg;
    localparam int CH_PER_LANE = 2;

    // Bit-clock events seen in the system-clock domain for one cycle.
    typedef struct packed {
        logic launch;   // edge on which data (and master word select) change
        logic sample;   // opposite edge, used to sample external word select
    } sck_ev_t;
endpackage

// File: rtl/sao_edge_detect.sv
// Turns the sampled bit clock into one-cycle launch/sample strobes.
// Assumes: sck is synchronous to clk and each level lasts at least one clk.
module sao_edge_detect
    import sao_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sck,
    input  logic    launch_fall,
    output sck_ev_t ev
);
    logic sck_q;
    logic rise;
    logic fall;

    // Remember last bit-clock level; in reset track it so no false edge appears.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= sck;
        else        sck_q <= sck;
    end

    // Classify the edge and map it to launch or sample by configuration.
    always_comb begin
        rise      = sck & ~sck_q;
        fall      = ~sck & sck_q;
        ev.launch = launch_fall ? fall : rise;
        ev.sample = launch_fall ? rise : fall;
    end
endmodule

// File: rtl/sao_frame_timer.sv
// Keeps the bit position inside the frame. In master mode it counts freely
// and drives word select; in slave mode it waits for a sampled word-select
// change and jumps to the start of the channel that level selects.
// Assumes: launch and sample strobes never coincide.
module sao_frame_timer
    import sao_pkg::*;
#(
    parameter  int SAMPLE_W   = 16,
    localparam int FRAME_BITS = 2 * SAMPLE_W,
    localparam int PW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sck_ev_t       ev,
    input  logic          is_master,
    input  logic          restart,
    input  logic          ws_in,
    output logic [PW-1:0] pos_nxt,
    output logic          running,
    output logic          running_nxt,
    output logic          frame_start,
    output logic          ws_out
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0] HALF = PW'(SAMPLE_W);

    logic [PW-1:0] pos;
    logic [PW-1:0] pos_wrap;
    logic [PW-1:0] tgt;
    logic          ws_known;
    logic          ws_seen;
    logic          pend;

    // Word-select level that belongs with bit position p (leads data by one bit).
    function automatic logic ws_level(input logic [PW-1:0] p);
        return (p >= HALF - 1'b1) && (p != LAST);
    endfunction

    // Next position and run state for this cycle.
    always_comb begin
        pos_wrap    = (pos == LAST) ? '0 : pos + 1'b1;
        pos_nxt     = pos;
        running_nxt = running;
        if (restart) begin
            pos_nxt     = LAST;
            running_nxt = 1'b0;
        end else if (ev.launch) begin
            if (is_master) begin
                pos_nxt     = pos_wrap;
                running_nxt = 1'b1;
            end else if (pend) begin
                pos_nxt     = tgt;
                running_nxt = 1'b1;
            end else if (running) begin
                pos_nxt = pos_wrap;
            end
        end
        frame_start = !restart && ev.launch && running_nxt && (pos_nxt == '0);
    end

    // Position, run state, slave alignment tracking and master word select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= LAST;
            running  <= 1'b0;
            ws_known <= 1'b0;
            ws_seen  <= 1'b0;
            pend     <= 1'b0;
            tgt      <= '0;
            ws_out   <= 1'b0;
        end else begin
            pos     <= pos_nxt;
            running <= running_nxt;
            if (restart) begin
                ws_known <= 1'b0;
                pend     <= 1'b0;
                ws_out   <= 1'b0;
            end else begin
                if (ev.launch) begin
                    pend <= 1'b0;
                    if (is_master) ws_out <= ws_level(pos_nxt);
                end
                if (ev.sample && !is_master) begin
                    if (!ws_known) begin
                        ws_known <= 1'b1;
                        ws_seen  <= ws_in;
                    end else if (ws_in != ws_seen) begin
                        ws_seen <= ws_in;
                        pend    <= 1'b1;
                        tgt     <= ws_in ? HALF : '0;
                    end
                end
            end
        end
    end

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
    assert_ws_on_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev.launch && !restart) |=> $stable(ws_out));
    assert_slave_ws_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !ws_out);
    assert_frame_from_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && is_master) |-> (pos == LAST));
endmodule

// File: rtl/sao_sample_store.sv
// One-set holding register behind a valid/ready handshake, plus the active
// set being serialised. Loads at each frame start; repeats on underrun.
// Assumes: load is a one-cycle strobe at the launch edge of a frame's first bit.
module sao_sample_store #(
    parameter  int SAMPLE_W = 16,
    parameter  int CHANNELS = 8,
    localparam int SET_W    = SAMPLE_W * CHANNELS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic [SET_W-1:0] s_data,
    output logic             s_ready,
    input  logic             load,
    output logic [SET_W-1:0] active_nxt,
    output logic             underrun
);
    logic [SET_W-1:0] hold;
    logic [SET_W-1:0] active;
    logic             hold_full;
    logic             accept;

    // Handshake and the set that will be in use after this cycle.
    always_comb begin
        s_ready    = !hold_full;
        accept     = s_valid && !hold_full;
        active_nxt = (load && hold_full) ? hold : active;
    end

    // Holding register, active set and sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            active    <= '0;
            hold_full <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            active <= active_nxt;
            if (load && !hold_full) underrun <= 1'b1;
            if (accept) begin
                hold      <= s_data;
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end
        end
    end

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);
    assert_load_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !s_ready) |=> s_ready);
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/sao_lane_serializer.sv
// Picks the current bit of each lane's left or right sample and registers it
// on the launch strobe. Lanes are forced low while framing is not running.
// Assumes: pos_nxt is below 2*SAMPLE_W.
module sao_lane_serializer #(
    parameter  int SAMPLE_W = 16,
    parameter  int LANES    = 4,
    parameter  int PW       = 5,
    localparam int SET_W    = SAMPLE_W * LANES * 2,
    localparam int BW       = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             restart,
    input  logic             running,
    input  logic             running_nxt,
    input  logic [PW-1:0]    pos_nxt,
    input  logic [SET_W-1:0] active_nxt,
    output logic [LANES-1:0] sd
);
    logic             right;
    logic [PW-1:0]    slot;
    logic [BW-1:0]    bsel;
    logic [LANES-1:0] lane_bit;

    // Channel half and MSB-first bit index from the frame position.
    always_comb begin
        right = pos_nxt >= PW'(SAMPLE_W);
        slot  = right ? pos_nxt - PW'(SAMPLE_W) : pos_nxt;
        bsel  = BW'(SAMPLE_W - 1 - int'(slot));
    end

    // One bit selector per lane: even channel on the left, odd on the right.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SAMPLE_W-1:0] left_w;
        logic [SAMPLE_W-1:0] right_w;
        assign left_w      = active_nxt[(2*g)*SAMPLE_W +: SAMPLE_W];
        assign right_w     = active_nxt[(2*g+1)*SAMPLE_W +: SAMPLE_W];
        assign lane_bit[g] = right ? right_w[bsel] : left_w[bsel];
    end

    // Lane outputs change only on launch; cleared by reset and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) sd <= '0;
        else if (launch)       sd <= running_nxt ? lane_bit : '0;
    end

    assert_sd_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !restart) |=> $stable(sd));
    assert_sd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (sd == '0));
endmodule

// File: rtl/multichan_audio_tx.sv
// Top of the multichannel serial audio transmitter: four lanes, two channels
// each, master or slave word select, selectable launch edge.
// Assumes: clk runs at least four times faster than sck; configuration is
// changed only while the caller accepts a framing restart.
module multichan_audio_tx #(
    parameter int SAMPLE_W = 16,
    parameter int LANES    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sck,
    input  logic                        cfg_master,
    input  logic                        cfg_launch_fall,
    input  logic                        s_valid,
    output logic                        s_ready,
    input  logic [LANES*2*SAMPLE_W-1:0] s_data,
    input  logic                        ws_in,
    output logic                        ws_out,
    output logic                        ws_oe,
    output logic [LANES-1:0]            sd,
    output logic                        underrun
);
    import sao_pkg::*;

    localparam int CHANNELS = LANES * CH_PER_LANE;
    localparam int PW       = $clog2(2 * SAMPLE_W);
    localparam int SET_W    = CHANNELS * SAMPLE_W;

    sck_ev_t          ev;
    logic             mode_q;
    logic             restart;
    logic [PW-1:0]    pos_nxt;
    logic             running;
    logic             running_nxt;
    logic             frame_start;
    logic [SET_W-1:0] active_nxt;

    // Registered mode: slave out of reset, follows the configuration input.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= cfg_master;
    end

    // Any mode change restarts framing.
    always_comb begin
        restart = (mode_q != cfg_master);
        ws_oe   = mode_q;
    end

    sao_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck         (sck),
        .launch_fall (cfg_launch_fall),
        .ev          (ev)
    );

    sao_frame_timer #(.SAMPLE_W(SAMPLE_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .is_master   (mode_q),
        .restart     (restart),
        .ws_in       (ws_in),
        .pos_nxt     (pos_nxt),
        .running     (running),
        .running_nxt (running_nxt),
        .frame_start (frame_start),
        .ws_out      (ws_out)
    );

    sao_sample_store #(.SAMPLE_W(SAMPLE_W), .CHANNELS(CHANNELS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_data     (s_data),
        .s_ready    (s_ready),
        .load       (frame_start),
        .active_nxt (active_nxt),
        .underrun   (underrun)
    );

    sao_lane_serializer #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .PW(PW)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (ev.launch),
        .restart     (restart),
        .running     (running),
        .running_nxt (running_nxt),
        .pos_nxt     (pos_nxt),
        .active_nxt  (active_nxt),
        .sd          (sd)
    );

    assert_reset_state_R4: assert property (@(posedge clk)
        !rst_n |=> (!ws_oe && !underrun && s_ready && (sd == '0)));
endmodule

// File: tb/test_multichan_audio_tx.sv
`timescale 1ns/1ps
module test_multichan_audio_tx;
    localparam int W     = 8;
    localparam int LANES = 4;
    localparam int SETW  = W * LANES * 2;
    localparam int FB    = 2 * W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             sck = 1'b0;
    logic             cfg_master = 1'b0;
    logic             cfg_launch_fall = 1'b0;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [SETW-1:0]  s_data = '0;
    logic             ws_in = 1'b0;
    logic             ws_out;
    logic             ws_oe;
    logic [LANES-1:0] sd;
    logic             underrun;

    multichan_audio_tx #(.SAMPLE_W(W), .LANES(LANES)) i_multichan_audio_tx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cfg_master(cfg_master),
        .cfg_launch_fall(cfg_launch_fall), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .ws_in(ws_in), .ws_out(ws_out), .ws_oe(ws_oe),
        .sd(sd), .underrun(underrun)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Bench model state, built from the requirements.
    int               m_pos = FB - 1;
    int               m_tgt = 0;
    int               ext_cnt = 5;
    bit               m_run = 0, m_known = 0, m_wsq = 0, m_pend = 0;
    bit               m_hold_full = 0, m_under = 0, exp_ws = 0, feed = 0;
    logic [SETW-1:0]  m_active = '0, m_hold = '0;
    logic [LANES-1:0] exp_sd = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit ws_for(input int p);
        return (p >= W - 1) && (p <= FB - 2);
    endfunction

    // R1: lane k sends channel 2k (left) or 2k+1 (right), MSB first.
    function automatic logic [LANES-1:0] bits_at(input int p, input logic [SETW-1:0] a);
        logic [LANES-1:0] b;
        for (int k = 0; k < LANES; k++) begin
            int ch = 2 * k + ((p >= W) ? 1 : 0);
            b[k] = a[ch * W + (W - 1 - (p % W))];
        end
        return b;
    endfunction

    task automatic model_restart();
        m_pos = FB - 1; m_run = 0; m_known = 0; m_pend = 0;
        exp_sd = '0; exp_ws = 0;
    endtask

    task automatic model_launch();
        bit adv = 0;
        if (cfg_master) begin
            m_pos = (m_pos == FB - 1) ? 0 : m_pos + 1;
            adv = 1;
            exp_ws = ws_for(m_pos);
        end else if (m_pend) begin
            m_pos = m_tgt; adv = 1;
        end else if (m_run) begin
            m_pos = (m_pos == FB - 1) ? 0 : m_pos + 1; adv = 1;
        end
        m_pend = 0;
        if (adv) m_run = 1;
        if (adv && m_pos == 0) begin
            if (m_hold_full) begin m_active = m_hold; m_hold_full = 0; end
            else m_under = 1;
        end
        exp_sd = m_run ? bits_at(m_pos, m_active) : '0;
    endtask

    // R6: external word select is taken on the non-launching edge.
    task automatic model_sample();
        if (cfg_master) return;
        if (!m_known) begin
            m_known = 1; m_wsq = ws_in;
        end else if (ws_in != m_wsq) begin
            m_wsq = ws_in; m_pend = 1; m_tgt = ws_in ? W : 0;
        end
    endtask

    task automatic push();
        logic [SETW-1:0] d = {$urandom, $urandom};
        @(negedge clk);
        s_valid = 1'b1; s_data = d;
        check(s_ready === 1'b1, "R8 ready before accept", 64'(s_ready), 64'd1);
        @(negedge clk);
        s_valid = 1'b0;
        m_hold = d; m_hold_full = 1;
    endtask

    task automatic half();
        bit launch;
        @(negedge clk);
        sck = ~sck;
        launch = cfg_launch_fall ? !sck : sck;
        if (launch) begin
            if (!cfg_master) begin
                ext_cnt = (ext_cnt + 1) % FB;
                ws_in = ws_for(ext_cnt);
            end
            model_launch();
        end else begin
            model_sample();
        end
        repeat (3) @(negedge clk);
        if (!m_run)
            check(sd === exp_sd, "R7 lanes quiet before alignment", 64'(sd), 64'(exp_sd));
        else if (cfg_master)
            check(sd === exp_sd, "R1 R5 R2 master lane data", 64'(sd), 64'(exp_sd));
        else
            check(sd === exp_sd, "R1 R5 R6 slave lane data", 64'(sd), 64'(exp_sd));
        if (cfg_master) begin
            check(ws_out === exp_ws, "R2 R3 word select", 64'(ws_out), 64'(exp_ws));
            check(ws_oe === 1'b1, "R3 word select driven", 64'(ws_oe), 64'd1);
        end else begin
            check(ws_oe === 1'b0, "R6 word select input", 64'(ws_oe), 64'd0);
        end
        check(underrun === m_under, "R9 underrun flag", 64'(underrun), 64'(m_under));
        check(s_ready === !m_hold_full, "R8 ready level", 64'(s_ready), 64'(!m_hold_full));
        if (feed && !m_hold_full) push();
    endtask

    task automatic run_bits(input int n);
        repeat (2 * n) half();
    endtask

    task automatic set_mode(input bit m, input bit f);
        bit changed = (m != cfg_master);
        @(negedge clk);
        cfg_master = m; cfg_launch_fall = f;
        repeat (2) @(negedge clk);
        if (changed) begin
            model_restart();
            check(sd === '0, "R7 restart clears lanes", 64'(sd), 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R4: master requested during reset, block still a slave.
        rst_n = 1'b0; cfg_master = 1'b1;
        repeat (4) @(negedge clk);
        check(ws_oe === 1'b0, "R4 slave in reset", 64'(ws_oe), 64'd0);
        check(sd === '0, "R4 lanes low", 64'(sd), 64'd0);
        check(s_ready === 1'b1, "R4 ready", 64'(s_ready), 64'd1);
        check(underrun === 1'b0, "R4 no underrun", 64'(underrun), 64'd0);
        cfg_master = 1'b0; cfg_launch_fall = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ws_oe === 1'b0, "R4 slave after reset", 64'(ws_oe), 64'd0);

        // Slave, rising launch; first word-select change leads into a right channel.
        ext_cnt = 5; ws_in = ws_for(ext_cnt);
        feed = 1;
        run_bits(3 * FB);

        // Master, rising launch, then starve to force a repeat.
        set_mode(1'b1, 1'b0);
        run_bits(3 * FB);
        feed = 0;
        run_bits(2 * FB);
        check(underrun === 1'b1, "R9 sticky after starve", 64'(underrun), 64'd1);
        feed = 1;
        run_bits(FB);

        // Master, falling launch without restart.
        set_mode(1'b1, 1'b1);
        run_bits(2 * FB);

        // Slave, falling launch; first change leads into a left channel.
        ext_cnt = 12; ws_in = ws_for(ext_cnt);
        set_mode(1'b0, 1'b1);
        run_bits(3 * FB);
        check(underrun === 1'b1, "R9 still set", 64'(underrun), 64'd1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule